// File: doc/BRIEF.md
# Active-Low Fault Status Register

This block holds the fault and status byte of a converter's control logic. Hardware event inputs latch active-low flags for supply undervoltage, reference undervoltage, configuration-CRC mismatch, internal memory fault and invalid-address write. A further flag records that a reset took place. A flag reads 0 while its fault is pending. The host returns a writable flag to 1 by writing 1 to its bit through a simple register write port. A combined active-low fault pin goes low while any of the analog or integrity faults is pending.

The block also keeps the host-written reference CRC of the configuration registers. After a write into the protected span, it compares that value against an externally computed CRC. The comparison only counts while checking is enabled.

Top module: `flt_stat_bank`

## Requirements
- R1: After reset the status byte reads 3Eh when the data-ready input is 0. The reset-occurred flag (bit 7) and the supply flag (bit 6) read 0, and bits 5 to 1 read 1.
- R2: Bit 4 of the status byte always reads 1. Bit 0 follows the data-ready input combinationally.
- R3: An event input clears its flag at the next clock edge: supply undervoltage clears bit 6 and memory fault clears bit 2. The reference-undervoltage event clears bit 5 only while the reference-monitor enable input is 1.
- R4: A rising edge of the power-down input clears bit 6 at the next edge. Staying in power-down does not clear it again.
- R5: A write to address 02h sets bit 7, bit 6, bit 5 and bit 3 to 1 for each data bit that is 1 in the same position. Data bits that are 0 leave the flag unchanged.
- R6: Every write re-evaluates bit 1. It becomes 0 when the address is above 0Fh and 1 when the address is between 00h and 0Fh.
- R7: The fault pin is low exactly when at least one of bits 6, 5, 3 and 2 of the status byte is 0.
- R8: A write to address 0Fh stores the host CRC. One cycle after any write to an address from 05h to 0Fh, bit 3 is cleared if checking is enabled and the calculated CRC input differs from the stored host CRC. A match, or checking disabled, leaves bit 3 unchanged.
- R9: A fault event in the same cycle as a host write-1 clear of that flag wins, so the flag reads 0.
- R10: Writes cannot restore bit 2. Once cleared, it stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| drdy_i | input | 1 | Data-ready indication shown in bit 0 |
| pwdn_i | input | 1 | Power-down mode level |
| ref_mon_en_i | input | 1 | Reference-monitor enable |
| ev_supply_uv_i | input | 1 | Supply undervoltage event |
| ev_ref_uv_i | input | 1 | Reference undervoltage event |
| ev_mem_fault_i | input | 1 | Internal memory fault event |
| crc_chk_en_i | input | 1 | Configuration CRC check enable |
| crc_calc_i | input | DATA_W | Internally calculated configuration CRC |
| status_o | output | 8 | Status byte |
| fault_n_o | output | 1 | Combined active-low fault pin |

## Verification
Flag updates from events, power-down entry and host writes are due at the first rising edge after the stimulus. The bench drives each stimulus on a falling edge and checks on the following falling edge. The CRC verdict is due one edge later than the write that triggers it. The bench therefore checks bit 3 twice: once a cycle after the write, where it must still be 1, and once a cycle after that. Bit 0 and the fault pin are combinational views, so the bench checks them in the same half-cycle in which it checks the registered flags.

// File: rtl/flt_pkg.sv
package flt_pkg;
    localparam int STAT_W = 8;

    // Bit positions of the status byte; the host and the pin logic decode these.
    localparam int B_RST  = 7;
    localparam int B_SUP  = 6;
    localparam int B_REF  = 5;
    localparam int B_ONE  = 4;
    localparam int B_CRC  = 3;
    localparam int B_MEM  = 2;
    localparam int B_WR   = 1;
    localparam int B_DRDY = 0;

    typedef struct packed {
        logic rst_seen_n;
        logic sup_ok_n;
        logic ref_ok_n;
        logic crc_ok_n;
        logic mem_ok_n;
        logic wr_ok_n;
        logic pwdn_prev;
    } flt_flags_t;
endpackage

// File: rtl/flt_addr_dec.sv
module flt_addr_dec #(
    parameter int ADDR_W    = 8,
    parameter int LAST_ADDR = 15,
    parameter int STAT_ADDR = 2,
    parameter int SPAN_LO   = 5,
    parameter int CRC_ADDR  = 15
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              valid_o,
    output logic              is_stat_o,
    output logic              is_crc_o,
    output logic              in_span_o
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(SPAN_LO);
    localparam logic [ADDR_W-1:0] CRC_A  = ADDR_W'(CRC_ADDR);

    always_comb begin
        valid_o   = (addr_i <= LAST_A);
        is_stat_o = (addr_i == STAT_A);
        is_crc_o  = (addr_i == CRC_A);
        in_span_o = (addr_i >= LO_A) && (addr_i <= CRC_A);
    end
endmodule

// File: rtl/flt_crc_cmp.sv
module flt_crc_cmp #(
    parameter int CRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             en_i,
    input  logic [CRC_W-1:0] host_i,
    input  logic [CRC_W-1:0] calc_i,
    output logic             mismatch_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d     = trig_i;
        mismatch_o = pend_q && en_i && (host_i != calc_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    // R8: a verdict only ever follows a write into the protected span by one cycle
    a_r8_verdict_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> $past(trig_i));
endmodule

// File: rtl/flt_stat_bank.sv
module flt_stat_bank
    import flt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int LAST_ADDR = 15,
    parameter int STAT_ADDR = 2,
    parameter int SPAN_LO   = 5,
    parameter int CRC_ADDR  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              drdy_i,
    input  logic              pwdn_i,
    input  logic              ref_mon_en_i,
    input  logic              ev_supply_uv_i,
    input  logic              ev_ref_uv_i,
    input  logic              ev_mem_fault_i,
    input  logic              crc_chk_en_i,
    input  logic [DATA_W-1:0] crc_calc_i,
    output logic [7:0]        status_o,
    output logic              fault_n_o
);
    localparam flt_flags_t FLAGS_RST = '{rst_seen_n: 1'b0, sup_ok_n: 1'b0, ref_ok_n: 1'b1,
                                         crc_ok_n: 1'b1, mem_ok_n: 1'b1, wr_ok_n: 1'b1,
                                         pwdn_prev: 1'b0};

    logic addr_ok, addr_stat, addr_crc, addr_span, crc_bad;
    flt_flags_t fl_d, fl_q;
    logic [DATA_W-1:0] host_crc_d, host_crc_q;

    flt_addr_dec #(
        .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR), .STAT_ADDR(STAT_ADDR),
        .SPAN_LO(SPAN_LO), .CRC_ADDR(CRC_ADDR)
    ) u_dec (
        .addr_i(wr_addr_i), .valid_o(addr_ok), .is_stat_o(addr_stat),
        .is_crc_o(addr_crc), .in_span_o(addr_span)
    );

    flt_crc_cmp #(.CRC_W(DATA_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .trig_i(wr_en_i && addr_span),
        .en_i(crc_chk_en_i), .host_i(host_crc_q), .calc_i(crc_calc_i),
        .mismatch_o(crc_bad)
    );

    always_comb begin
        fl_d       = fl_q;
        host_crc_d = host_crc_q;
        fl_d.pwdn_prev = pwdn_i;

        // host side: write-1 restores, write re-evaluates address validity
        if (wr_en_i) begin
            fl_d.wr_ok_n = addr_ok;
            if (addr_stat) begin
                if (wr_data_i[B_RST]) fl_d.rst_seen_n = 1'b1;
                if (wr_data_i[B_SUP]) fl_d.sup_ok_n   = 1'b1;
                if (wr_data_i[B_REF]) fl_d.ref_ok_n   = 1'b1;
                if (wr_data_i[B_CRC]) fl_d.crc_ok_n   = 1'b1;
            end
            if (addr_crc) host_crc_d = wr_data_i;
        end

        // hardware events come last so they win against a clear
        if (ev_supply_uv_i || (pwdn_i && !fl_q.pwdn_prev)) fl_d.sup_ok_n = 1'b0;
        if (ev_ref_uv_i && ref_mon_en_i)                   fl_d.ref_ok_n = 1'b0;
        if (crc_bad)                                       fl_d.crc_ok_n = 1'b0;
        if (ev_mem_fault_i)                                fl_d.mem_ok_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q       <= FLAGS_RST;
            host_crc_q <= '0;
        end else begin
            fl_q       <= fl_d;
            host_crc_q <= host_crc_d;
        end
    end

    always_comb begin
        status_o         = '0;
        status_o[B_RST]  = fl_q.rst_seen_n;
        status_o[B_SUP]  = fl_q.sup_ok_n;
        status_o[B_REF]  = fl_q.ref_ok_n;
        status_o[B_ONE]  = 1'b1;
        status_o[B_CRC]  = fl_q.crc_ok_n;
        status_o[B_MEM]  = fl_q.mem_ok_n;
        status_o[B_WR]   = fl_q.wr_ok_n;
        status_o[B_DRDY] = drdy_i;
        fault_n_o = fl_q.sup_ok_n & fl_q.ref_ok_n & fl_q.crc_ok_n & fl_q.mem_ok_n;
    end

    // R2: constant-one bit at position 4
    a_r2_fixed_bit: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[B_ONE]);
    // R3: reference flag may only fall while monitoring was enabled
    a_r3_ref_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[B_REF]) |-> $past(ref_mon_en_i));
    // R4: entering power-down marks the supply flag
    a_r4_pwdn_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwdn_i) |=> !status_o[B_SUP]);
    // R6: write outside the map shows in bit 1 next cycle
    a_r6_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i > ADDR_W'(LAST_ADDR))) |=> !status_o[B_WR]);
    // R7: pin low whenever a monitored flag is low
    a_r7_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[B_SUP] || !status_o[B_REF] || !status_o[B_CRC] || !status_o[B_MEM])
        |-> !fault_n_o);
    // R9: event beats a simultaneous clear
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_supply_uv_i |=> !status_o[B_SUP]);
    // R10: memory flag is sticky
    a_r10_mem_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[B_MEM] |=> !status_o[B_MEM]);
endmodule

// File: tb/sim_flt_stat_bank.sv
module sim_flt_stat_bank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, crc_calc = '0;
    logic drdy = 1'b0, pwdn = 1'b0, ref_en = 1'b0;
    logic ev_sup = 1'b0, ev_ref = 1'b0, ev_mem = 1'b0, crc_en = 1'b0;
    logic [7:0] status;
    logic fault_n;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flt_stat_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .drdy_i(drdy), .pwdn_i(pwdn), .ref_mon_en_i(ref_en),
        .ev_supply_uv_i(ev_sup), .ev_ref_uv_i(ev_ref), .ev_mem_fault_i(ev_mem),
        .crc_chk_en_i(crc_en), .crc_calc_i(crc_calc), .status_o(status),
        .fault_n_o(fault_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive a write on a falling edge; returns on the next falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();
        chk("R1 reset status", status, 8'h3E);
        chk("R1 reset pin", {7'b0, fault_n}, 8'h00);

        drdy = 1'b1; #1;
        chk("R2 drdy mirror", status, 8'h3F);
        drdy = 1'b0; #1;
        chk("R2 bit4 one", {7'b0, status[4]}, 8'h01);

        // R5 clear all writable flags
        wr(8'h02, 8'hFF);
        chk("R5 clear all", status, 8'hFE);
        chk("R7 pin idle high", {7'b0, fault_n}, 8'h01);

        // R6 exhaustive address sweep with zero data
        for (int a = 0; a < 256; a++) begin
            wr(a[7:0], 8'h00);
            chk("R6 addr sweep", {7'b0, status[1]}, (a <= 15) ? 8'h01 : 8'h00);
        end
        wr(8'h02, 8'h00);
        chk("R5 zero write no restore", status, 8'hFE);

        // R3 reference gating
        @(negedge clk); ev_ref = 1'b1; cycle(); ev_ref = 1'b0;
        chk("R3 ref ignored when disabled", {7'b0, status[5]}, 8'h01);
        ref_en = 1'b1;
        @(negedge clk); ev_ref = 1'b1; cycle(); ev_ref = 1'b0; ref_en = 1'b0;
        chk("R3 ref latched", {7'b0, status[5]}, 8'h00);
        chk("R7 pin on ref", {7'b0, fault_n}, 8'h00);
        wr(8'h02, 8'h20);
        chk("R5 ref restored", status, 8'hFE);

        // R4 power-down entry
        @(negedge clk); pwdn = 1'b1; cycle();
        chk("R4 pwdn entry", {7'b0, status[6]}, 8'h00);
        wr(8'h02, 8'h40);
        cycle();
        chk("R4 held pwdn no reclear", {7'b0, status[6]}, 8'h01);
        pwdn = 1'b0;

        // R9 event wins over clear
        @(negedge clk); wr_en = 1'b1; wr_addr = 8'h02; wr_data = 8'hFF; ev_sup = 1'b1;
        cycle(); wr_en = 1'b0; ev_sup = 1'b0;
        chk("R9 event beats clear", {7'b0, status[6]}, 8'h00);
        wr(8'h02, 8'h40);

        // R8 CRC compare timing and gating
        crc_en = 1'b1; crc_calc = 8'h5A;
        wr(8'h0F, 8'h5A);
        cycle();
        chk("R8 match keeps flag", {7'b0, status[3]}, 8'h01);
        crc_calc = 8'h33;
        wr(8'h05, 8'h00);
        chk("R8 not yet after one edge", {7'b0, status[3]}, 8'h01);
        cycle();
        chk("R8 mismatch clears", {7'b0, status[3]}, 8'h00);
        wr(8'h02, 8'h08);
        crc_en = 1'b0;
        wr(8'h0E, 8'h00);
        cycle();
        chk("R8 disabled no effect", {7'b0, status[3]}, 8'h01);
        crc_en = 1'b1;
        wr(8'h04, 8'h00);
        cycle();
        chk("R8 outside span no compare", {7'b0, status[3]}, 8'h01);
        crc_en = 1'b0;

        // R7 pin over all combinations of three restorable flags
        for (int k = 0; k < 8; k++) begin
            wr(8'h02, 8'hE8);
            if (k[0]) begin @(negedge clk); ev_sup = 1'b1; cycle(); ev_sup = 1'b0; end
            if (k[1]) begin
                @(negedge clk); ref_en = 1'b1; ev_ref = 1'b1; cycle();
                ev_ref = 1'b0; ref_en = 1'b0;
            end
            if (k[2]) begin
                crc_en = 1'b1; crc_calc = 8'hA5;
                wr(8'h05, 8'h00); cycle(); crc_en = 1'b0;
            end
            chk("R3 combo flags", {5'b0, status[3], status[5], status[6]},
                {5'b0, ~k[2], ~k[1], ~k[0]});
            chk("R7 combo pin", {7'b0, fault_n}, (k == 0) ? 8'h01 : 8'h00);
        end

        // R10 memory flag sticky
        wr(8'h02, 8'hFF);
        @(negedge clk); ev_mem = 1'b1; cycle(); ev_mem = 1'b0;
        chk("R3 mem latched", {7'b0, status[2]}, 8'h00);
        wr(8'h02, 8'hFF);
        chk("R10 mem stays", status, 8'hFA);
        chk("R7 pin on mem", {7'b0, fault_n}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule